// File: doc/BRIEF.md
# Gated Sample Integrator with Baseline Subtraction

The block sums a stream of signed ADC samples, one per clock, over a programmable time window that opens a set number of clocks after a trigger. A second window, with its own delay but the same length, sums the input over a quiet stretch to measure the baseline. When both windows have closed, the block presents the integral minus the baseline as one signed word and strobes a valid flag for one cycle. A busy flag covers the whole measurement.

Delays and the shared gate length are run-time inputs. They are captured on the trigger edge, so a new setting takes effect from the next measurement. Two channels are served by placing two copies of the block side by side.

Top module: `gated_integrator`

## Requirements
- R1: After reset, busy_o and valid_o are low and result_o is zero.
- R2: trig_i is active high and sampled on the rising clock edge. When busy_o is low, a high trig_i starts a measurement, and busy_o is high from the following cycle.
- R3: Number the clock edges after the trigger edge k = 1, 2, ... The integration window sums, sign-extended, the samples present at edges k = D+1 to D+L, where D is int_dly_i and L is gate_len_i as captured at the trigger edge.
- R4: The baseline window sums the samples at edges k = B+1 to B+L, where B is off_dly_i. result_o is the 29-bit signed value (integration sum) minus (baseline sum).
- R5: Each window takes its samples independently, so the two windows may overlap, coincide or come in either order.
- R6: For L > 0, valid_o is high for exactly one cycle, following edge k = max(D,B)+L+1, and busy_o falls at that same edge.
- R7: For L = 0, the result is zero and valid_o follows edge k = 1, whatever the delays are.
- R8: A trigger that arrives while busy_o is high has no effect. The result belongs to the first trigger, and no new measurement starts.
- R9: result_o stays unchanged from one completion to the next.
- R10: With L = 65535 and full-scale samples of opposite sign in the two windows, the result is exact. There is no overflow in either sum or in the difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Measurement trigger, active high |
| sample_i | input | 12 | Signed ADC sample |
| int_dly_i | input | 16 | Integration window delay in clocks |
| off_dly_i | input | 16 | Baseline window delay in clocks |
| gate_len_i | input | 16 | Length of both windows in samples |
| result_o | output | 29 | Integration sum minus baseline sum, signed |
| valid_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | Measurement in progress |

## Verification
The hardest case to reach from the ports is a window at full length. Reaching it takes more than 131 000 clocks of extreme samples, with the two windows placed so that each one sees only one polarity. The bench drives the baseline window over the first 65535 samples at the negative full-scale value. It places the integration window directly after it, at the positive full-scale value, and compares the result with the exact arithmetic difference. Small delay and length combinations are swept exhaustively to cover overlapping windows, reversed window order and zero length. On alternate runs the trigger is held high for the whole measurement.

// File: rtl/gint_pkg.sv
package gint_pkg;
  localparam int unsigned SMP_W = 12;
  localparam int unsigned LEN_W = 16;
  localparam int unsigned DLY_W = 16;
  localparam int unsigned N_WIN = 2;
  localparam int unsigned WIN_INT = 0;
  localparam int unsigned WIN_OFF = 1;
endpackage

// File: rtl/gint_window.sv
module gint_window #(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned DLY_W = 16,
  parameter int unsigned ACC_W = SMP_W + LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [SMP_W-1:0] sample_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             active_o
);
  localparam int unsigned EXT_W = ACC_W - SMP_W;

  logic [DLY_W-1:0] dly_q;
  logic [LEN_W-1:0] len_q;
  logic [ACC_W-1:0] acc_q;
  logic             active_q;
  logic [ACC_W-1:0] smp_ext;

  assign smp_ext = {{EXT_W{sample_i[SMP_W-1]}}, sample_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q    <= '0;
      len_q    <= '0;
      acc_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      dly_q    <= dly_i;
      len_q    <= len_i;
      acc_q    <= '0;
      active_q <= (len_i != '0);
    end else if (active_q) begin
      if (dly_q != '0) begin
        dly_q <= dly_q - 1'b1;
      end else begin
        acc_q <= acc_q + smp_ext;
        len_q <= len_q - 1'b1;
        if (len_q == LEN_W'(1)) active_q <= 1'b0;
      end
    end
  end

  assign acc_o    = acc_q;
  assign active_o = active_q;

  // window only runs inside a measurement
  p_win_in_meas_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> busy_i);

  // closed window holds its sum
  p_acc_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !start_i) |=> $stable(acc_q));

endmodule

// File: rtl/gint_ctrl.sv
module gint_ctrl #(
  parameter int unsigned N_WIN = 2,
  parameter int unsigned ACC_W = 28,
  parameter int unsigned RES_W = ACC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [N_WIN-1:0] win_active_i,
  input  logic [ACC_W-1:0] acc_int_i,
  input  logic [ACC_W-1:0] acc_off_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned PAD_W = RES_W - ACC_W;

  logic             busy_q;
  logic             valid_q;
  logic [RES_W-1:0] result_q;
  logic             start;
  logic             done;
  logic [RES_W-1:0] diff;

  assign start = trig_i & ~busy_q;
  assign done  = busy_q & ~(|win_active_i);
  assign diff  = {{PAD_W{acc_int_i[ACC_W-1]}}, acc_int_i}
               - {{PAD_W{acc_off_i[ACC_W-1]}}, acc_off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= done;
      if (start) busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      if (done) result_q <= diff;
    end
  end

  assign start_o  = start;
  assign busy_o   = busy_q;
  assign valid_o  = valid_q;
  assign result_o = result_q;

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  p_busy_falls_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $fell(busy_q));

  p_busy_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(trig_i));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(result_q));

endmodule

// File: rtl/gated_integrator.sv
module gated_integrator
  import gint_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SMP_W,
  parameter int unsigned GLEN_W   = LEN_W,
  parameter int unsigned GDLY_W   = DLY_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                trig_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [GDLY_W-1:0]   int_dly_i,
  input  logic [GDLY_W-1:0]   off_dly_i,
  input  logic [GLEN_W-1:0]   gate_len_i,
  output logic [SAMPLE_W+GLEN_W:0] result_o,
  output logic                valid_o,
  output logic                busy_o
);
  localparam int unsigned ACC_W = SAMPLE_W + GLEN_W;
  localparam int unsigned RES_W = ACC_W + 1;

  logic              start;
  logic              busy;
  logic [N_WIN-1:0]  win_active;
  logic [ACC_W-1:0]  win_acc [N_WIN];
  logic [GDLY_W-1:0] win_dly [N_WIN];

  assign win_dly[WIN_INT] = int_dly_i;
  assign win_dly[WIN_OFF] = off_dly_i;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    gint_window #(
      .SMP_W(SAMPLE_W),
      .LEN_W(GLEN_W),
      .DLY_W(GDLY_W),
      .ACC_W(ACC_W)
    ) u_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .busy_i  (busy),
      .dly_i   (win_dly[w]),
      .len_i   (gate_len_i),
      .sample_i(sample_i),
      .acc_o   (win_acc[w]),
      .active_o(win_active[w])
    );
  end

  gint_ctrl #(
    .N_WIN(N_WIN),
    .ACC_W(ACC_W),
    .RES_W(RES_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .win_active_i(win_active),
    .acc_int_i   (win_acc[WIN_INT]),
    .acc_off_i   (win_acc[WIN_OFF]),
    .start_o     (start),
    .busy_o      (busy),
    .valid_o     (valid_o),
    .result_o    (result_o)
  );

  assign busy_o = busy;

endmodule

// File: tb/gated_integrator_bench.sv
module gated_integrator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               trig = 1'b0;
  logic signed [11:0] sample = '0;
  logic [15:0]        int_dly = '0;
  logic [15:0]        off_dly = '0;
  logic [15:0]        glen = '0;
  logic signed [28:0] result;
  logic               valid;
  logic               busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_integrator u_gated_integrator (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .trig_i    (trig),
    .sample_i  (sample),
    .int_dly_i (int_dly),
    .off_dly_i (off_dly),
    .gate_len_i(glen),
    .result_o  (result),
    .valid_o   (valid),
    .busy_o    (busy)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int smp(input int k, input int seed, input bit full, input int split);
    if (full) return (k <= split) ? -2048 : 2047;
    return ((k * 173 + seed * 59) % 4096) - 2048;
  endfunction

  task automatic run(input int di, input int dof, input int len, input int seed,
                     input bit hold, input bit full);
    longint exp_int = 0;
    longint exp_off = 0;
    longint exp_res;
    longint last;
    int mx = (di > dof) ? di : dof;
    int lat = (len == 0) ? 1 : mx + len + 1;
    int seen = -1;
    int nval = 0;
    for (int k = 1; k <= mx + len; k++) begin
      if (k > di && k <= di + len) exp_int += smp(k, seed, full, 65535);
      if (k > dof && k <= dof + len) exp_off += smp(k, seed, full, 65535);
    end
    exp_res = exp_int - exp_off;
    @(negedge clk);
    int_dly = 16'(di); off_dly = 16'(dof); glen = 16'(len); trig = 1'b1;
    for (int k = 1; k <= lat + 3; k++) begin
      @(negedge clk);
      if (k == 1) chk("R2 busy after trigger", longint'(busy), 1);
      if (valid) begin
        nval++;
        seen = k - 1;
        chk((len == 0) ? "R7 zero-length result" :
            (full ? "R10 full-scale result" : "R3 R4 R5 result"),
            longint'(result), exp_res);
        chk("R6 busy falls with valid", longint'(busy), 0);
      end
      trig = (hold && k <= lat) ? 1'b1 : 1'b0;
      sample = 12'(smp(k, seed, full, 65535));
    end
    chk((len == 0) ? "R7 valid latency" : "R6 valid latency", longint'(seen), longint'(lat));
    chk("R6 single valid", longint'(nval), 1);
    chk(hold ? "R8 no restart" : "R2 idle after done", longint'(busy), 0);
    last = longint'(result);
    repeat (3) @(negedge clk);
    chk("R9 result held", longint'(result), last);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy reset", longint'(busy), 0);
    chk("R1 valid reset", longint'(valid), 0);
    chk("R1 result reset", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (int_dly_set[i]) ;
    for (int di = 0; di < 4; di++)
      for (int dof = 0; dof < 6; dof += 2)
        for (int len = 0; len < 8; len += (len < 2 ? 1 : 5)) begin
          run(di, dof, len, s, s[0], 1'b0);
          s++;
        end
    run(9, 0, 4, 77, 1'b1, 1'b0);
    run(0, 9, 4, 78, 1'b0, 1'b0);
    run(65535, 0, 65535, 0, 1'b0, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int int_dly_set[1];

endmodule